// File: doc/BRIEF.md
# Two-Group Interrupt Coalescing Timer

This block gathers single-cycle completion pulses from four receive rings and four transmit rings and turns them into fewer interrupts. Two independent groups, A and B, each own a 32-bit configuration word. The word selects which ring sources belong to the group, the number of member events that justifies an interrupt, and the longest time a pending event may wait, counted in periods of an external 10 µs tick strobe. A group's interrupt flag rises on whichever limit is met first, and stays up until software acknowledges it.

Ring sources that no enabled group claims are not delayed: each such pulse shows up one cycle later on a per-ring direct output. A group whose threshold field is zero is switched off, so its rings fall through to the direct outputs. When both groups select the same ring, group A takes it while A is enabled.

Top module: `irq_coalescer`

## Requirements
- R1: Configuration bits 31:28 select receive rings 3,2,1,0 (bit 28 is receive ring 0) and bits 27:24 select transmit rings 3,2,1,0 (bit 24 is transmit ring 0) as group members.
- R2: Bits 20:16 hold the event threshold (1..31); the group flag rises in the cycle after the member events counted since the last acknowledge reach the threshold, with several simultaneous member pulses each counted.
- R3: Bits 10:0 hold the maximum delay; the delay counter advances by one on each tick that arrives while at least one member event was already counted (not in the event's own cycle) and the flag is low, and the flag rises in the cycle after the tick that brings it to the maximum delay (a value of 0 acts like 1).
- R4: Once raised, a group flag stays high until that group is acknowledged or disabled.
- R5: An acknowledge clears the group's flag, event counter and delay counter at the same clock edge; the flag is low in the next cycle unless the member events of the acknowledge cycle alone reach the threshold.
- R6: Member events arriving in the same cycle as the acknowledge are counted into the new interval.
- R7: A threshold of 0 disables the group: its flag stays low, its counters are held clear, and its member rings pass to the direct outputs.
- R8: A ring selected by both enabled groups belongs to group A only; group B ignores it.
- R9: A ring pulse not claimed by any enabled group appears on its direct output bit one cycle later for exactly one cycle; claimed pulses never appear there.
- R10: The event counter saturates at 31 and never wraps, so a burst of more than 31 member events still raises a threshold of 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_done | input | 4 | Receive ring completion pulses, bit k for ring k |
| tx_done | input | 4 | Transmit ring completion pulses, bit k for ring k |
| tick_10us | input | 1 | One-cycle strobe every 10 µs |
| cfg_a | input | 32 | Group A configuration word |
| cfg_b | input | 32 | Group B configuration word |
| ack_a | input | 1 | Acknowledge for group A |
| ack_b | input | 1 | Acknowledge for group B |
| irq_a | output | 1 | Group A coalesced interrupt flag |
| irq_b | output | 1 | Group B coalesced interrupt flag |
| rx_direct | output | 4 | Unclaimed receive pulses, delayed one cycle |
| tx_direct | output | 4 | Unclaimed transmit pulses, delayed one cycle |

## Verification
The assertions assume that ring pulses, ticks and acknowledges are sampled as plain per-cycle levels and that the configuration words only change between whole cycles, so a disable or re-enable takes effect at the next edge. The bench drives every input at the falling edge and holds it for exactly one cycle, changes configuration only while no events are in flight, and clears both groups by writing zero thresholds before each directed case, so every expected flag value follows from the counts of pulses and ticks alone.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
   localparam int CNT_W   = 5;
   localparam int DLY_W   = 11;
   localparam int THR_LSB = 16;
   localparam int DLY_LSB = 0;
   localparam int CFG_W   = 32;
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
endpackage

// File: rtl/irqc_route.sv
module irqc_route #(
   parameter int SRC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SRC_W-1:0] src_ev,
   input  logic [SRC_W-1:0] sel_a,
   input  logic [SRC_W-1:0] sel_b,
   input  logic             en_a,
   input  logic             en_b,
   output logic [SRC_W-1:0] mem_a,
   output logic [SRC_W-1:0] mem_b,
   output logic [SRC_W-1:0] direct_q
);
   logic [SRC_W-1:0] claim_a, claim_b;

   // Group A wins shared rings only while it is enabled (R8)
   assign claim_a = sel_a & {SRC_W{en_a}};
   assign claim_b = sel_b & ~claim_a & {SRC_W{en_b}};
   assign mem_a   = src_ev & claim_a;
   assign mem_b   = src_ev & claim_b;

   always_ff @(posedge clk) begin
      if (!rst_n) direct_q <= '0;
      else        direct_q <= src_ev & ~(claim_a | claim_b);
   end

   p_pass_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((direct_q & $past(claim_a | claim_b)) == '0));
   p_overlap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (en_a && (sel_a & src_ev) != '0) |-> ((mem_b & sel_a) == '0));
endmodule

// File: rtl/irqc_group.sv
module irqc_group
   import irqc_pkg::*;
#(
   parameter int SRC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SRC_W-1:0] mem_ev,
   input  logic             tick_i,
   input  logic             ack_i,
   input  logic             en_i,
   input  logic [CNT_W-1:0] thr_i,
   input  logic [DLY_W-1:0] maxd_i,
   output logic             irq_o
);
   localparam int PC_W  = $clog2(SRC_W + 1);
   localparam int SUM_W = CNT_W + 1;

   logic [CNT_W-1:0] cnt_q, base, cnt_n;
   logic [DLY_W-1:0] dly_q;
   logic [PC_W-1:0]  pc;
   logic [SUM_W-1:0] sum;
   logic [DLY_W:0]   dly_inc;
   logic             irq_q, adv, hit_cnt, hit_dly;

   always_comb begin
      pc = '0;
      for (int i = 0; i < SRC_W; i++) pc = pc + PC_W'(mem_ev[i]);
   end

   assign base    = ack_i ? '0 : cnt_q;
   assign sum     = {1'b0, base} + SUM_W'(pc);
   assign cnt_n   = (sum > SUM_W'(CNT_MAX)) ? CNT_MAX : sum[CNT_W-1:0];
   assign hit_cnt = (cnt_n >= thr_i);
   assign adv     = tick_i && (cnt_q != '0) && !irq_q && !ack_i;
   assign dly_inc = {1'b0, dly_q} + 1'b1;
   assign hit_dly = adv && (dly_inc >= {1'b0, maxd_i});

   always_ff @(posedge clk) begin
      if (!rst_n || !en_i) begin
         irq_q <= 1'b0;
         cnt_q <= '0;
         dly_q <= '0;
      end else if (ack_i) begin
         irq_q <= hit_cnt;
         cnt_q <= cnt_n;
         dly_q <= '0;
      end else begin
         irq_q <= irq_q | hit_cnt | hit_dly;
         cnt_q <= cnt_n;
         if (adv) dly_q <= dly_inc[DLY_W-1:0];
      end
   end

   assign irq_o = irq_q;

   p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !ack_i && en_i) |=> irq_o);
   p_ack_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && mem_ev == '0) |=> (!irq_o && cnt_q == '0));
   p_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> (!irq_o && cnt_q == '0));
   p_cnt_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == CNT_MAX && !ack_i && en_i) |=> cnt_q == CNT_MAX);
   p_dly_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0) |-> (dly_q == '0));
endmodule

// File: rtl/irq_coalescer.sv
module irq_coalescer
   import irqc_pkg::*;
#(
   parameter int NUM_RINGS = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_RINGS-1:0] rx_done,
   input  logic [NUM_RINGS-1:0] tx_done,
   input  logic                 tick_10us,
   input  logic [CFG_W-1:0]     cfg_a,
   input  logic [CFG_W-1:0]     cfg_b,
   input  logic                 ack_a,
   input  logic                 ack_b,
   output logic                 irq_a,
   output logic                 irq_b,
   output logic [NUM_RINGS-1:0] rx_direct,
   output logic [NUM_RINGS-1:0] tx_direct
);
   localparam int SRC_W   = 2 * NUM_RINGS;
   localparam int SEL_LSB = CFG_W - SRC_W;
   localparam int NGRP    = 2;

   generate
      if (NUM_RINGS < 1 || SRC_W > CFG_W - (THR_LSB + CNT_W))
         $error("irq_coalescer: NUM_RINGS does not fit the configuration word");
   endgenerate

   logic [SRC_W-1:0] src, direct_q;
   logic [CFG_W-1:0] cfg  [NGRP];
   logic [SRC_W-1:0] sel  [NGRP];
   logic [SRC_W-1:0] mem  [NGRP];
   logic [NGRP-1:0]  en, ack, irq;

   // Source bit order matches the selection field: receive rings on top (R1)
   assign src    = {rx_done, tx_done};
   assign cfg[0] = cfg_a;
   assign cfg[1] = cfg_b;
   assign ack    = {ack_b, ack_a};

   irqc_route #(.SRC_W(SRC_W)) u_route (
      .clk(clk), .rst_n(rst_n), .src_ev(src),
      .sel_a(sel[0]), .sel_b(sel[1]), .en_a(en[0]), .en_b(en[1]),
      .mem_a(mem[0]), .mem_b(mem[1]), .direct_q(direct_q)
   );

   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      assign sel[g] = cfg[g][SEL_LSB +: SRC_W];
      assign en[g]  = (cfg[g][THR_LSB +: CNT_W] != '0);
      irqc_group #(.SRC_W(SRC_W)) u_grp (
         .clk(clk), .rst_n(rst_n), .mem_ev(mem[g]), .tick_i(tick_10us),
         .ack_i(ack[g]), .en_i(en[g]),
         .thr_i(cfg[g][THR_LSB +: CNT_W]), .maxd_i(cfg[g][DLY_LSB +: DLY_W]),
         .irq_o(irq[g])
      );
   end

   assign irq_a     = irq[0];
   assign irq_b     = irq[1];
   assign rx_direct = direct_q[SRC_W-1:NUM_RINGS];
   assign tx_direct = direct_q[NUM_RINGS-1:0];

   p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (src == '0) |=> (direct_q == '0));
endmodule

// File: tb/tb_irq_coalescer.sv
module tb_irq_coalescer;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 11;
   // {rx[4], tx[4], tick, ack_a, ack_b, exp_irq_a, exp_irq_b, exp_rx_dir[4], exp_tx_dir[4]}
   localparam logic [20:0] VEC [NV] = '{
      {4'b0001, 4'b0000, 3'b000, 2'b00, 4'b0000, 4'b0000}, // R1 R2 count 1
      {4'b0011, 4'b0000, 3'b000, 2'b10, 4'b0000, 4'b0000}, // R2 reaches 3
      {4'b0100, 4'b0000, 3'b000, 2'b10, 4'b0100, 4'b0000}, // R4 R9 rx2 unclaimed
      {4'b0001, 4'b0000, 3'b010, 2'b00, 4'b0000, 4'b0000}, // R5 R6 ack with event
      {4'b0000, 4'b0001, 3'b000, 2'b00, 4'b0000, 4'b0000}, // R1 B count 1
      {4'b0000, 4'b0000, 3'b100, 2'b00, 4'b0000, 4'b0000}, // R3 tick 1
      {4'b0000, 4'b0000, 3'b100, 2'b01, 4'b0000, 4'b0000}, // R3 tick 2 fires B
      {4'b0000, 4'b1000, 3'b000, 2'b01, 4'b0000, 4'b1000}, // R4 R9 tx3 unclaimed
      {4'b0000, 4'b0011, 3'b001, 2'b00, 4'b0000, 4'b0010}, // R5 R6 ack B
      {4'b0000, 4'b0001, 3'b000, 2'b01, 4'b0000, 4'b0000}, // R2 B reaches 2
      {4'b0000, 4'b0000, 3'b011, 2'b00, 4'b0000, 4'b0000}  // R5 ack both
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic [3:0] rx_done = '0, tx_done = '0;
   logic tick_10us = 1'b0, ack_a = 1'b0, ack_b = 1'b0;
   logic [31:0] cfg_a = '0, cfg_b = '0;
   logic irq_a, irq_b;
   logic [3:0] rx_direct, tx_direct;
   int checks = 0, failures = 0;

   irq_coalescer dut (
      .clk(clk), .rst_n(rst_n), .rx_done(rx_done), .tx_done(tx_done),
      .tick_10us(tick_10us), .cfg_a(cfg_a), .cfg_b(cfg_b),
      .ack_a(ack_a), .ack_b(ack_b), .irq_a(irq_a), .irq_b(irq_b),
      .rx_direct(rx_direct), .tx_direct(tx_direct)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic cyc(input logic [3:0] rx, input logic [3:0] tx,
                      input logic tk, input logic aa, input logic ab);
      @(negedge clk);
      rx_done = rx; tx_done = tx; tick_10us = tk; ack_a = aa; ack_b = ab;
      @(posedge clk);
      #1;
   endtask

   task automatic clear_groups();
      cfg_a = '0; cfg_b = '0;
      cyc(4'h0, 4'h0, 1'b0, 1'b0, 1'b0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      #1;
      chk("reset outputs", {22'd0, irq_a, irq_b, rx_direct, tx_direct}, 32'd0);

      // Table: A = rx0,rx1 thr 3 maxd 2047; B = tx0 thr 2 maxd 2
      cfg_a = 32'h3003_07FF;
      cfg_b = 32'h0102_0002;
      for (int v = 0; v < NV; v++) begin
         cyc(VEC[v][20:17], VEC[v][16:13], VEC[v][12], VEC[v][11], VEC[v][10]);
         checks++;
         if ({irq_a, irq_b, rx_direct, tx_direct} !== VEC[v][9:0]) begin
            failures++;
            $display("FAIL table vec %0d (R1 R2 R3 R4 R5 R6 R9) actual=%b expected=%b",
                     v, {irq_a, irq_b, rx_direct, tx_direct}, VEC[v][9:0]);
         end
      end

      // R7: threshold 0 disables group A, rx0 passes through
      clear_groups();
      cfg_a = 32'h1000_0005;
      cyc(4'b0001, 4'h0, 1'b1, 1'b0, 1'b0);
      chk("R7 direct", {28'd0, rx_direct}, 32'h1);
      chk("R7 irq_a low", {31'd0, irq_a}, 32'd0);
      cyc(4'h0, 4'h0, 1'b1, 1'b0, 1'b0);
      chk("R7 irq_a after tick", {31'd0, irq_a}, 32'd0);

      // R8: rx1 in both groups, thr 1 each
      clear_groups();
      cfg_a = 32'h2001_0000; cfg_b = 32'h2001_0000;
      cyc(4'b0010, 4'h0, 1'b0, 1'b0, 1'b0);
      chk("R8 A owns shared ring", {30'd0, irq_a, irq_b}, 32'b10);
      cfg_a = 32'h2000_0000;
      cyc(4'b0010, 4'h0, 1'b0, 1'b0, 1'b0);
      chk("R8 B takes ring when A off", {26'd0, irq_a, irq_b, rx_direct}, {26'd0, 2'b01, 4'b0000});

      // R10: all rings, thr 31, 8 events per cycle
      clear_groups();
      cfg_a = 32'hFF1F_07FF;
      for (int k = 0; k < 3; k++) cyc(4'hF, 4'hF, 1'b0, 1'b0, 1'b0);
      chk("R10 below 31", {31'd0, irq_a}, 32'd0);
      cyc(4'hF, 4'hF, 1'b0, 1'b0, 1'b0);
      chk("R10 saturated count fires", {31'd0, irq_a}, 32'd1);

      // R3: tx2 thr 31, maxd 0; tick in event cycle does not count
      clear_groups();
      cfg_b = 32'h041F_0000;
      cyc(4'h0, 4'b0100, 1'b1, 1'b0, 1'b0);
      chk("R3 same-cycle tick ignored", {31'd0, irq_b}, 32'd0);
      cyc(4'h0, 4'h0, 1'b1, 1'b0, 1'b0);
      chk("R3 maxd 0 fires on first tick", {31'd0, irq_b}, 32'd1);
      cyc(4'h0, 4'h0, 1'b0, 1'b0, 1'b1);
      chk("R5 ack clears", {31'd0, irq_b}, 32'd0);

      // R3: maxd 3, idle cycles between ticks do not advance
      clear_groups();
      cfg_b = 32'h041F_0003;
      cyc(4'h0, 4'b0100, 1'b0, 1'b0, 1'b0);
      cyc(4'h0, 4'h0, 1'b1, 1'b0, 1'b0);
      cyc(4'h0, 4'h0, 1'b0, 1'b0, 1'b0);
      cyc(4'h0, 4'h0, 1'b1, 1'b0, 1'b0);
      chk("R3 two ticks", {31'd0, irq_b}, 32'd0);
      cyc(4'h0, 4'h0, 1'b1, 1'b0, 1'b0);
      chk("R3 third tick fires", {31'd0, irq_b}, 32'd1);
      cyc(4'h0, 4'h0, 1'b0, 1'b0, 1'b0);
      chk("R4 flag held", {31'd0, irq_b}, 32'd1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule